// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block is the host-side loader for an SRAM-based programmable device that takes its configuration as a passive serial bitstream. A start request makes the host pull the active-low configuration request low for a fixed number of cycles and then release it. The host then waits for the target's active-low status line to read high. Once it does, the host streams bytes from a valid/ready source onto a single data line, least significant bit first. Each bit goes out with a configuration clock that the host generates by dividing its own clock.

After the last byte the data line goes to a fixed idle level and the configuration clock keeps running. The host watches for the target's load-complete line to rise. When the init stage is enabled, it also waits for the init-complete line. It then reports success, or stops with an error code. A status line that falls during the load aborts the cycle. So do the status line, load-complete line and init-complete line each failing to arrive within its own limit. All three inputs from the target are asynchronous and pass through two-flop synchronizers.

Top module: `ps_cfg_host`

## Requirements
- R1: Out of reset, cfg_n_o is 1, dclk_o is 0, data_o is IDLE_LVL, and busy_o, done_o, err_o and byte_ready_o are 0.
- R2: A start_i accepted while idle drives cfg_n_o low for exactly RST_CYC cycles. A start_i while busy_o is 1 has no effect: no second low pulse occurs and the current load continues.
- R3: After cfg_n_o returns high, no clock edge is produced until the synchronized status line reads high. If it stays low, err_o rises with err_code_o = 1 on exactly the STAT_TMO-th cycle after cfg_n_o went high.
- R4: Bytes are sent least significant bit first. At each rising edge of dclk_o during the load, data_o holds the next bit of the byte stream.
- R5: Every high phase of dclk_o lasts exactly CLK_DIV cycles, and data_o does not change while dclk_o is high. Data changes only together with a falling edge.
- R6: A byte is taken on a cycle where byte_valid_i and byte_ready_o are both 1. byte_ready_o is raised only during the load and only while no byte is held. dclk_o stays low while the host waits for a byte. byte_last_i marks the final byte.
- R7: If the status line falls during the load or its trailing phase, the host returns to idle with err_o = 1 and err_code_o = 2, dclk_o low, and at most one further clock edge.
- R8: After the last bit, data_o is IDLE_LVL and dclk_o keeps toggling until the load-complete line reads high. If that line is still low after DONE_XTRA extra rising edges, the host stops with err_code_o = 3.
- R9: With INIT_EN set, done_o rises only after the init-complete line is high. If that line stays low for INIT_TMO cycles, the host stops with err_code_o = 4 and done_o = 0.
- R10: While idle, dclk_o is 0 and data_o is IDLE_LVL.
- R11: An accepted start_i clears done_o, err_o and err_code_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a configuration cycle |
| byte_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | byte_i is valid |
| byte_last_i | input | 1 | byte_i is the final byte |
| byte_ready_o | output | 1 | Host can take a byte |
| cfg_n_o | output | 1 | Configuration request to target, active low |
| stat_n_i | input | 1 | Target status, asynchronous |
| cdone_i | input | 1 | Target load-complete, asynchronous |
| init_done_i | input | 1 | Target init-complete, asynchronous |
| dclk_o | output | 1 | Generated configuration clock |
| data_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | A configuration cycle is in progress |
| done_o | output | 1 | Last cycle ended successfully |
| err_o | output | 1 | Last cycle ended with an error |
| err_code_o | output | 3 | 0 none, 1 status timeout, 2 status drop, 3 load-complete timeout, 4 init timeout |

## Verification
The reset pulse length and the status timeout are due on exact cycles. The low run of cfg_n_o is counted sample by sample and must equal RST_CYC. err_o must stay low for the first STAT_TMO-1 samples after cfg_n_o rises and be high on the STAT_TMO-th. Serial data is checked on every clock, at the sample where dclk_o is first seen high, against a bit queue built from the bytes sent. The same per-clock model counts high-phase lengths and watches data stability. Results that depend on the synchronizers are due two to three cycles after the target input changes: error on a status drop, done after init-complete, the trailing-edge count. These are checked against bounds or edge counts, not a single cycle.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_WSTAT, ST_SHIFT, ST_FLUSH, ST_WINIT
  } state_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_STAT_TMO  = 3'd1,
    ERR_STAT_DROP = 3'd2,
    ERR_DONE_TMO  = 3'd3,
    ERR_INIT_TMO  = 3'd4
  } err_e;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/ps_clkgen.sv
module ps_clkgen #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic dclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          dclk_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(DIV - 1));
  assign rise_o = tick && !dclk_q;
  assign fall_o = tick && dclk_q;
  assign dclk_o = dclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      dclk_q <= 1'b0;
    end else if (run_i) begin
      if (tick) begin
        cnt_q  <= '0;
        dclk_q <= ~dclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  rise_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && !clr_i) |=> dclk_o);
  // R5
  fall_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !dclk_o);
endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host
  import ps_cfg_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int RST_CYC   = 8,
  parameter int STAT_TMO  = 64,
  parameter int DONE_XTRA = 16,
  parameter int INIT_TMO  = 64,
  parameter bit INIT_EN   = 1'b1,
  parameter bit IDLE_LVL  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  output logic              cfg_n_o,
  input  logic              stat_n_i,
  input  logic              cdone_i,
  input  logic              init_done_i,
  output logic              dclk_o,
  output logic              data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        err_code_o
);
  localparam int T1   = (RST_CYC > STAT_TMO) ? RST_CYC : STAT_TMO;
  localparam int TMAX = (T1 > INIT_TMO) ? T1 : INIT_TMO;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int XW   = $clog2(DONE_XTRA + 1);
  localparam int BW   = $clog2(BYTE_W);

  state_e            state_q, state_d;
  logic [TW-1:0]     tmr_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BW-1:0]     bidx_q;
  logic              have_q, last_q;
  logic [XW-1:0]     xcnt_q;
  logic              done_q, err_q;
  err_e              ecode_q, ecode_d;
  logic              err_set, ok_set;

  logic [2:0] syn;
  logic       stat_s, cdone_s, init_s;
  logic       run, clr, rise, fall;

  ps_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({init_done_i, cdone_i, stat_n_i}),
    .q_o   (syn)
  );
  assign stat_s  = syn[0];
  assign cdone_s = syn[1];
  assign init_s  = syn[2];

  assign run = ((state_q == ST_SHIFT) && have_q) || (state_q == ST_FLUSH);
  assign clr = !((state_d == ST_SHIFT) || (state_d == ST_FLUSH));

  ps_clkgen #(.DIV(CLK_DIV)) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (clr),
    .dclk_o(dclk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  always_comb begin
    state_d = state_q;
    err_set = 1'b0;
    ok_set  = 1'b0;
    ecode_d = ERR_NONE;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RST;
      ST_RST:   if (tmr_q == TW'(RST_CYC - 1)) state_d = ST_WSTAT;
      ST_WSTAT: begin
        if (stat_s) state_d = ST_SHIFT;
        else if (tmr_q == TW'(STAT_TMO - 1)) begin
          state_d = ST_IDLE; err_set = 1'b1; ecode_d = ERR_STAT_TMO;
        end
      end
      ST_SHIFT: begin
        if (!stat_s) begin
          state_d = ST_IDLE; err_set = 1'b1; ecode_d = ERR_STAT_DROP;
        end else if (fall && bidx_q == BW'(BYTE_W - 1) && last_q) begin
          state_d = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (!stat_s) begin
          state_d = ST_IDLE; err_set = 1'b1; ecode_d = ERR_STAT_DROP;
        end else if (cdone_s) begin
          if (INIT_EN) state_d = ST_WINIT;
          else begin state_d = ST_IDLE; ok_set = 1'b1; end
        end else if (fall && xcnt_q == XW'(DONE_XTRA)) begin
          state_d = ST_IDLE; err_set = 1'b1; ecode_d = ERR_DONE_TMO;
        end
      end
      ST_WINIT: begin
        if (init_s) begin
          state_d = ST_IDLE; ok_set = 1'b1;
        end else if (tmr_q == TW'(INIT_TMO - 1)) begin
          state_d = ST_IDLE; err_set = 1'b1; ecode_d = ERR_INIT_TMO;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      shreg_q <= '0;
      bidx_q  <= '0;
      have_q  <= 1'b0;
      last_q  <= 1'b0;
      xcnt_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ecode_q <= ERR_NONE;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) tmr_q <= '0;
      else if (state_q inside {ST_RST, ST_WSTAT, ST_WINIT}) tmr_q <= tmr_q + 1'b1;

      if (state_q == ST_IDLE && start_i) begin
        done_q  <= 1'b0;
        err_q   <= 1'b0;
        ecode_q <= ERR_NONE;
      end
      if (err_set) begin
        err_q   <= 1'b1;
        ecode_q <= ecode_d;
      end
      if (ok_set) done_q <= 1'b1;

      if (state_q == ST_SHIFT) begin
        if (byte_valid_i && byte_ready_o) begin
          shreg_q <= byte_i;
          bidx_q  <= '0;
          have_q  <= 1'b1;
          last_q  <= byte_last_i;
        end else if (fall) begin
          if (bidx_q == BW'(BYTE_W - 1)) have_q <= 1'b0;
          else begin
            shreg_q <= shreg_q >> 1;
            bidx_q  <= bidx_q + 1'b1;
          end
        end
      end else begin
        have_q <= 1'b0;
      end

      if (state_q != ST_FLUSH) xcnt_q <= '0;
      else if (rise) xcnt_q <= xcnt_q + 1'b1;
    end
  end

  assign byte_ready_o = (state_q == ST_SHIFT) && !have_q;
  assign cfg_n_o      = (state_q != ST_RST);
  assign data_o       = (state_q == ST_SHIFT) ? shreg_q[0] : IDLE_LVL;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign err_code_o   = ecode_q;

  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |=> (!dclk_o || $stable(data_o)));
  // R6
  load_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_ready_o) |-> !dclk_o);
  // R7
  stat_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SHIFT) && !stat_s) |=> (!busy_o && err_o && !dclk_o));
  // R10
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!dclk_o && data_o == IDLE_LVL));
  // R9
  done_xor_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R11
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (!done_o && !err_o && busy_o));
endmodule

// File: tb/test_ps_cfg_host.sv
`timescale 1ns/1ps
module test_ps_cfg_host;
  localparam int  DIV   = 2;
  localparam int  RSTC  = 8;
  localparam int  STMO  = 64;
  localparam int  XTRA  = 16;
  localparam int  ITMO  = 64;
  localparam bit  IDLV  = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       start = 1'b0;
  logic [7:0] byte_d = '0;
  logic       byte_valid = 1'b0, byte_last = 1'b0, byte_ready;
  logic       cfg_n, stat_n = 1'b0, cdone = 1'b0, init_done = 1'b0;
  logic       dclk, data, busy, done, err;
  logic [2:0] ecode;

  ps_cfg_host #(.CLK_DIV(DIV), .RST_CYC(RSTC), .STAT_TMO(STMO), .DONE_XTRA(XTRA),
                .INIT_TMO(ITMO), .INIT_EN(1'b1), .IDLE_LVL(IDLV)) i_ps_cfg_host (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_i(byte_d),
    .byte_valid_i(byte_valid), .byte_last_i(byte_last), .byte_ready_o(byte_ready),
    .cfg_n_o(cfg_n), .stat_n_i(stat_n), .cdone_i(cdone), .init_done_i(init_done),
    .dclk_o(dclk), .data_o(data), .busy_o(busy), .done_o(done), .err_o(err),
    .err_code_o(ecode));

  // test configuration (written by the sequencer only)
  logic [7:0] img [16];
  int nbytes = 0, src_gap = 0, stat_dly = 0, drop_at = -1;
  int cd_k = 0, init_dly = 0;
  bit stat_en = 1'b1, cd_en = 1'b1, init_en = 1'b1;

  // monitor state
  int m_chk = 0, m_bad = 0, t_chk = 0, t_bad = 0;
  int rise_cnt = 0, low_run = 0, last_low = 0, falls = 0, hi_run = 0;
  int sc = 0, ic = 0, cyc = 0;
  bit p_dclk = 0, p_data = 0, p_cfg = 1, p_done = 0;

  task automatic mchk(input bit ok, input string tag, input int act, input int exp);
    m_chk++;
    if (!ok) begin
      m_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tchk(input bit ok, input string tag, input int act, input int exp);
    t_chk++;
    if (!ok) begin
      t_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", m_chk + t_chk + 1, m_bad + t_bad + 1);
      $finish;
    end
  end

  // byte source: restarts whenever a new cycle pulls cfg_n low
  int  src_idx = 0, gap_cnt = 0;
  bit  taken = 0;
  always @(negedge clk) begin
    if (!rst_n || !cfg_n) begin
      src_idx = 0; gap_cnt = 0; taken = 0; byte_valid = 0;
    end else begin
      if (taken) begin src_idx++; gap_cnt = src_gap; taken = 0; end
      if (gap_cnt > 0) begin
        gap_cnt--; byte_valid = 0;
      end else begin
        byte_valid = (src_idx < nbytes);
        byte_d     = img[src_idx % 16];
        byte_last  = (src_idx == nbytes - 1);
      end
      taken = byte_valid && byte_ready;
    end
  end

  // target model and per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cfg_n) begin
        stat_n = 0; sc = 0; cdone = 0; init_done = 0; ic = 0; rise_cnt = 0;
        low_run++;
      end else begin
        if (!p_cfg) begin last_low = low_run; low_run = 0; end
        if (drop_at >= 0 && rise_cnt >= drop_at) stat_n = 0;
        else if (stat_en) begin
          if (sc >= stat_dly) stat_n = 1; else sc++;
        end
        if (cd_en && rise_cnt >= nbytes * 8 + cd_k) cdone = 1;
        if (cdone && init_en) begin
          if (ic >= init_dly) init_done = 1; else ic++;
        end
      end
      if (p_cfg && !cfg_n) falls++;

      if (dclk && !p_dclk) begin
        if (rise_cnt < nbytes * 8) // R4 LSB first
          mchk(data == img[rise_cnt / 8][rise_cnt % 8], "R4 bit", data, img[rise_cnt / 8][rise_cnt % 8]);
        else // R8 idle level after last bit
          mchk(data == IDLV, "R8 trailing data", data, IDLV);
        rise_cnt++;
        hi_run = 1;
      end else if (dclk && p_dclk) begin
        hi_run++;
        mchk(data == p_data, "R5 data stable", data, p_data);
      end else if (!dclk && p_dclk && busy) begin
        mchk(hi_run == DIV, "R5 high phase", hi_run, DIV);
      end

      if (done && !p_done) mchk(init_done, "R9 done before init", 0, 1);
      if (!busy) mchk(!dclk && data == IDLV, "R10 idle lines", {dclk, data}, {1'b0, IDLV});
      p_dclk = dclk; p_data = data; p_cfg = cfg_n; p_done = done;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  initial begin
    int f0, rc;
    for (int i = 0; i < 16; i++) img[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    // R1
    tchk(cfg_n && !dclk && data == IDLV && !busy && !done && !err && !byte_ready,
         "R1 reset state", {cfg_n, dclk, data, busy, done, err, byte_ready}, 7'b1010000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // success, byte gaps, start ignored mid-load
    img[0] = 8'hA5; img[1] = 8'h01; img[2] = 8'h80; img[3] = 8'h3C;
    nbytes = 4; src_gap = 3; stat_dly = 5; cd_k = 2; init_dly = 10;
    f0 = falls;
    pulse_start();
    for (int i = 0; i < 2000 && rise_cnt < 10; i++) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle(5000);
    tchk(falls == f0 + 1, "R2 start while busy", falls - f0, 1);
    tchk(last_low == RSTC, "R2 reset pulse", last_low, RSTC);
    tchk(rise_cnt >= 32, "R6 all bytes shifted", rise_cnt, 32);
    tchk(done && !err && ecode == 3'd0, "R8 success", {done, err, ecode}, 5'b10000);
    tchk(init_done, "R9 init seen", init_done, 1);

    // status timeout with exact cycle
    stat_en = 0;
    pulse_start();
    for (int i = 0; i < 100 && !cfg_n; i++) @(negedge clk);
    tchk(!err && !done, "R11 start clears flags", {done, err}, 0);
    for (int i = 1; i <= STMO; i++) begin
      @(negedge clk);
      if (i < STMO) begin
        if (err) tchk(0, "R3 early timeout", i, STMO);
      end else tchk(err && ecode == 3'd1, "R3 status timeout", {err, ecode}, 4'b1001);
    end
    tchk(rise_cnt == 0 && !busy, "R3 no clock without status", rise_cnt, 0);

    // status drop during the load
    stat_en = 1; stat_dly = 2; src_gap = 0; drop_at = 20;
    pulse_start();
    tchk(!err && busy, "R11 err cleared", err, 0);
    wait_idle(5000);
    tchk(err && ecode == 3'd2, "R7 drop code", ecode, 2);
    tchk(rise_cnt <= 21, "R7 at most one more edge", rise_cnt, 21);
    rc = rise_cnt;
    repeat (20) @(negedge clk);
    tchk(rise_cnt == rc && !dclk, "R7 clock halted", rise_cnt, rc);

    // load-complete never rises
    drop_at = -1; cd_en = 0; nbytes = 2;
    pulse_start();
    wait_idle(5000);
    tchk(err && ecode == 3'd3, "R8 done timeout code", ecode, 3);
    tchk(rise_cnt == 16 + XTRA, "R8 trailing edges", rise_cnt, 16 + XTRA);

    // init-complete never rises
    cd_en = 1; cd_k = 0; init_en = 0;
    pulse_start();
    wait_idle(5000);
    tchk(err && ecode == 3'd4 && !done, "R9 init timeout", ecode, 4);

    // single byte, no delays
    init_en = 1; init_dly = 0; stat_dly = 0; nbytes = 1; img[0] = 8'h6B;
    pulse_start();
    wait_idle(5000);
    tchk(done && !err && ecode == 3'd0, "R8 single byte", {done, err, ecode}, 5'b10000);
    tchk(last_low == RSTC, "R2 reset pulse again", last_low, RSTC);
    tchk(!dclk && data == IDLV, "R10 final idle", {dclk, data}, {1'b0, IDLV});

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", m_chk + t_chk, m_bad + t_bad);
    $finish;
  end
endmodule